// File: doc/BRIEF.md
# Timer Channel Status Flags

This block keeps the three sticky event flags of one 16-bit timer channel and raises their interrupt requests. One flag records that the counter wrapped, in either direction. The other two flags record a compare match or an input capture on general register A or general register B. The flags are packed into an 8-bit status byte that the CPU reads through a simple strobe port. The unused upper bits of that byte always read as 1.

Software clears a flag in two steps. First it reads the byte while the flag is 1, which arms that flag. Then it writes a 0 to that flag's bit. A 0 written to a flag that has not been armed does nothing, and a 1 written to a flag bit never has an effect. The prescaler, the capture pin logic, the waveform generation and the quadrature decoding sit outside this block. They reach it only as single-cycle strobes, a counter value with a step strobe, a direction bit and an up/down mode bit. The interrupt enables also come from outside.

Top module: `tmr_status_flags`

## Requirements
- R1: The status byte places the wrap flag at bit 2, the B match/capture flag at bit 1 and the A match/capture flag at bit 0. Bits 7 to 3 always read as 1.
- R2: Asynchronous reset, or a cycle with `standby` high, loads the byte with 0xF8 and discards any read arming.
- R3: When `cntStep` is high with `cntValue` = 0xFFFF and the counter counting up, the wrap flag is 1 from the next cycle onward.
- R4: When `cntStep` is high with `cntValue` = 0x0000, `cntDown` = 1 and `upDownEn` = 1, the wrap flag sets (underflow). When `upDownEn` = 0, `cntDown` is ignored and the counter counts up, so a step at 0x0000 does not set the flag.
- R5: `matchA` or `captA` sets flag A, and `matchB` or `captB` sets flag B, from the next cycle.
- R6: Writing 1 to a flag bit leaves that flag unchanged.
- R7: Writing 0 to a set flag that was not read as 1 since the last write leaves it set.
- R8: A read arms only the flags that are 1 in that cycle. A following write clears each armed flag whose written bit is 0, and every write disarms all flags.
- R9: If a set event and a clearing write hit the same flag in the same cycle, the flag is 1 afterwards.
- R10: Each `irq` bit is 1 exactly when the matching flag and `irqEnable` bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Synchronous reinitialise to 0xF8 |
| cntValue | input | 16 | Counter value before the current step |
| cntStep | input | 1 | Counter advances this cycle |
| cntDown | input | 1 | Step direction, 1 = down |
| upDownEn | input | 1 | Up/down counting mode active |
| matchA | input | 1 | Compare match strobe, register A |
| captA | input | 1 | Input capture strobe, register A |
| matchB | input | 1 | Compare match strobe, register B |
| captB | input | 1 | Input capture strobe, register B |
| regRd | input | 1 | CPU read strobe for the status byte |
| regWr | input | 1 | CPU write strobe for the status byte |
| wrData | input | 8 | CPU write data |
| irqEnable | input | 3 | Interrupt enables, same bit order as the flags |
| rdData | output | 8 | Status byte |
| irq | output | 3 | Interrupt requests, same bit order as the flags |

## Verification
The properties assume that a read strobe and a write strobe never occur in the same cycle. They also assume that every event strobe lasts one cycle and is separate from the step strobe, so that each hold-or-set property has one cause. The directed tasks drive at most one of `regRd` and `regWr` per cycle, hold every strobe for exactly one cycle, and return the strobes to idle before they sample the status byte. Collisions between a set event and a clearing write are created on purpose, and only with a write that is not a read.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;
  localparam int FLAG_N = 3;
  localparam int REG_W  = 8;
  localparam int WRAP_BIT = 2;
  localparam int B_BIT    = 1;
  localparam int A_BIT    = 0;

  typedef struct packed {
    logic [FLAG_N-1:0] setMask;
    logic [FLAG_N-1:0] clrMask;
    logic              init;
  } flagCmd_t;
endpackage

// File: rtl/tmr_flag_ctrl.sv
module tmr_flag_ctrl
  import tmr_flag_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic [CNT_W-1:0]  cntValue,
  input  logic              cntStep,
  input  logic              cntDown,
  input  logic              upDownEn,
  input  logic              matchA,
  input  logic              captA,
  input  logic              matchB,
  input  logic              captB,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [FLAG_N-1:0] flagQ,
  output flagCmd_t          cmd
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MIN = '0;

  logic [FLAG_N-1:0] armQ;
  logic countingDown;
  logic upWrap;
  logic downWrap;
  logic unusedWrHi;

  assign unusedWrHi   = ^wrData[REG_W-1:FLAG_N];
  assign countingDown = cntDown && upDownEn;
  assign upWrap       = cntStep && !countingDown && (cntValue == CNT_MAX);
  assign downWrap     = cntStep && countingDown && (cntValue == CNT_MIN);

  always_comb begin
    cmd = '0;
    cmd.init              = standby;
    cmd.setMask[WRAP_BIT] = upWrap || downWrap;
    cmd.setMask[B_BIT]    = matchB || captB;
    cmd.setMask[A_BIT]    = matchA || captA;
    if (regWr) begin
      cmd.clrMask = armQ & ~wrData[FLAG_N-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armQ <= '0;
    end else if (standby || regWr) begin
      armQ <= '0;
    end else if (regRd) begin
      armQ <= armQ | flagQ;
    end
  end
endmodule

// File: rtl/tmr_flag_dp.sv
module tmr_flag_dp
  import tmr_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  flagCmd_t          cmd,
  input  logic [FLAG_N-1:0] irqEnable,
  output logic [FLAG_N-1:0] flagQ,
  output logic [REG_W-1:0]  rdData,
  output logic [FLAG_N-1:0] irq
);
  localparam int RSVD_W = REG_W - FLAG_N;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagQ <= '0;
    end else if (cmd.init) begin
      flagQ <= '0;
    end else begin
      flagQ <= (flagQ & ~cmd.clrMask) | cmd.setMask;
    end
  end

  assign rdData = {{RSVD_W{1'b1}}, flagQ};

  for (genvar i = 0; i < FLAG_N; i++) begin : g_irq
    assign irq[i] = flagQ[i] & irqEnable[i];
  end
endmodule

// File: rtl/tmr_status_flags.sv
module tmr_status_flags
  import tmr_flag_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic [CNT_W-1:0]  cntValue,
  input  logic              cntStep,
  input  logic              cntDown,
  input  logic              upDownEn,
  input  logic              matchA,
  input  logic              captA,
  input  logic              matchB,
  input  logic              captB,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [FLAG_N-1:0] irqEnable,
  output logic [REG_W-1:0]  rdData,
  output logic [FLAG_N-1:0] irq
);
  flagCmd_t          cmd;
  logic [FLAG_N-1:0] flagQ;

  tmr_flag_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .standby(standby),
    .cntValue(cntValue), .cntStep(cntStep), .cntDown(cntDown), .upDownEn(upDownEn),
    .matchA(matchA), .captA(captA), .matchB(matchB), .captB(captB),
    .regRd(regRd), .regWr(regWr), .wrData(wrData),
    .flagQ(flagQ), .cmd(cmd)
  );

  tmr_flag_dp u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .irqEnable(irqEnable),
    .flagQ(flagQ), .rdData(rdData), .irq(irq)
  );
endmodule

// File: rtl/tmr_status_flags_chk.sv
module tmr_status_flags_chk
  import tmr_flag_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              standby,
  input logic [CNT_W-1:0]  cntValue,
  input logic              cntStep,
  input logic              cntDown,
  input logic              matchA,
  input logic              captA,
  input logic              regWr,
  input logic [REG_W-1:0]  wrData,
  input logic [FLAG_N-1:0] irqEnable,
  input logic [REG_W-1:0]  rdData,
  input logic [FLAG_N-1:0] irq
);
  // R1
  rsvd_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdData[REG_W-1:FLAG_N] == {(REG_W-FLAG_N){1'b1}});

  // R2
  standby_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> rdData == 8'hF8);

  // R3
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cntStep && !cntDown && cntValue == {CNT_W{1'b1}} && !standby) |=> rdData[WRAP_BIT]);

  // R5
  a_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((matchA || captA) && !standby) |=> rdData[A_BIT]);

  // R6
  write_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regWr && wrData[A_BIT] && rdData[A_BIT] && !standby) |=> rdData[A_BIT]);

  // R7
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdData[B_BIT] && !regWr && !standby) |=> rdData[B_BIT]);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (rdData[FLAG_N-1:0] & irqEnable));
endmodule

bind tmr_status_flags tmr_status_flags_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby),
  .cntValue(cntValue), .cntStep(cntStep), .cntDown(cntDown),
  .matchA(matchA), .captA(captA), .regWr(regWr), .wrData(wrData),
  .irqEnable(irqEnable), .rdData(rdData), .irq(irq)
);

// File: tb/tmr_status_flags_bench.sv
module tmr_status_flags_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0;
  logic [15:0] cntValue = '0;
  logic        cntStep = 1'b0;
  logic        cntDown = 1'b0;
  logic        upDownEn = 1'b0;
  logic        matchA = 1'b0;
  logic        captA = 1'b0;
  logic        matchB = 1'b0;
  logic        captB = 1'b0;
  logic        regRd = 1'b0;
  logic        regWr = 1'b0;
  logic [7:0]  wrData = '0;
  logic [2:0]  irqEnable = '0;
  logic [7:0]  rdData;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  tmr_status_flags u_tmr_status_flags (
    .clk(clk), .rst_n(rst_n), .standby(standby),
    .cntValue(cntValue), .cntStep(cntStep), .cntDown(cntDown), .upDownEn(upDownEn),
    .matchA(matchA), .captA(captA), .matchB(matchB), .captB(captB),
    .regRd(regRd), .regWr(regWr), .wrData(wrData),
    .irqEnable(irqEnable), .rdData(rdData), .irq(irq)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    cntStep = 0; matchA = 0; captA = 0; matchB = 0; captB = 0;
    regRd = 0; regWr = 0; standby = 0;
  endtask

  task automatic stepCnt(input logic [15:0] v, input logic dn, input logic ud);
    @(negedge clk);
    cntValue = v; cntDown = dn; upDownEn = ud; cntStep = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic evt(input logic mA, input logic cA, input logic mB, input logic cB);
    @(negedge clk);
    matchA = mA; captA = cA; matchB = mB; captB = cB;
    @(negedge clk);
    idle();
  endtask

  task automatic rdReg();
    @(negedge clk);
    regRd = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic wrReg(input logic [7:0] d);
    @(negedge clk);
    regWr = 1; wrData = d;
    @(negedge clk);
    idle();
  endtask

  task automatic goStandby();
    @(negedge clk);
    standby = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic testReset();
    chk("R2 reset value", rdData, 8'hF8);
    chk("R1 reserved bits", {5'b0, rdData[7:3] == 5'h1F ? 3'b1 : 3'b0}, 8'h01);
  endtask

  task automatic testOverflow();
    stepCnt(16'hFFFE, 0, 0);
    chk("R3 no wrap before max", rdData, 8'hF8);
    stepCnt(16'hFFFF, 0, 0);
    chk("R3 overflow sets bit 2", rdData, 8'hFC);
    goStandby();
  endtask

  task automatic testUnderflow();
    stepCnt(16'h0000, 1, 0);
    chk("R4 down ignored without up/down mode", rdData, 8'hF8);
    stepCnt(16'h0000, 1, 1);
    chk("R4 underflow sets bit 2", rdData, 8'hFC);
    goStandby();
    stepCnt(16'hFFFF, 1, 0);
    chk("R4 down ignored, wrap at max", rdData, 8'hFC);
    goStandby();
  endtask

  task automatic testEvents();
    evt(1, 0, 0, 0);
    chk("R5 matchA", rdData, 8'hF9);
    goStandby();
    evt(0, 1, 0, 0);
    chk("R5 captA", rdData, 8'hF9);
    goStandby();
    evt(0, 0, 1, 0);
    chk("R5 matchB", rdData, 8'hFA);
    goStandby();
    evt(0, 0, 0, 1);
    chk("R5 captB", rdData, 8'hFA);
    goStandby();
  endtask

  task automatic testNoRead();
    evt(1, 0, 1, 0);
    wrReg(8'h00);
    chk("R7 write 0 without read keeps flags", rdData, 8'hFB);
    rdReg();
    wrReg(8'h00);
    chk("R8 read then write 0 clears", rdData, 8'hF8);
  endtask

  task automatic testWriteOne();
    evt(0, 1, 0, 1);
    rdReg();
    wrReg(8'hFF);
    chk("R6 write 1 keeps flags", rdData, 8'hFB);
    wrReg(8'h00);
    chk("R8 write disarms all", rdData, 8'hFB);
    goStandby();
  endtask

  task automatic testSelectiveArm();
    evt(1, 0, 0, 0);
    rdReg();
    evt(0, 0, 1, 0);
    wrReg(8'h00);
    chk("R8 only flags read as 1 clear", rdData, 8'hFA);
    rdReg();
    wrReg(8'hFE);
    chk("R8 armed flag written 1 stays", rdData, 8'hFA);
    goStandby();
  endtask

  task automatic testCollision();
    evt(1, 0, 0, 0);
    rdReg();
    @(negedge clk);
    regWr = 1; wrData = 8'h00; matchA = 1;
    @(negedge clk);
    idle();
    chk("R9 set wins over clear", rdData, 8'hF9);
    goStandby();
  endtask

  task automatic testIrq();
    evt(1, 0, 1, 0);
    irqEnable = 3'b001;
    #1;
    chk("R10 irq A only", {5'b0, irq}, 8'h01);
    irqEnable = 3'b110;
    #1;
    chk("R10 irq B only", {5'b0, irq}, 8'h02);
    irqEnable = 3'b111;
    stepCnt(16'hFFFF, 0, 0);
    chk("R10 irq all", {5'b0, irq}, 8'h07);
    rdReg();
    goStandby();
    chk("R2 standby clears flags", rdData, 8'hF8);
    chk("R10 irq idle after standby", {5'b0, irq}, 8'h00);
    evt(1, 0, 0, 0);
    wrReg(8'h00);
    chk("R2 standby discards arming", rdData, 8'hF9);
    irqEnable = 3'b000;
    goStandby();
  endtask

  task automatic testAsyncReset();
    evt(0, 0, 1, 1);
    @(negedge clk);
    rst_n = 0;
    #1;
    chk("R2 async reset", rdData, 8'hF8);
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    testReset();
    testOverflow();
    testUnderflow();
    testEvents();
    testNoRead();
    testWriteOne();
    testSelectiveArm();
    testCollision();
    testIrq();
    testAsyncReset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule